// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs single read and write transfers on an external bus where the address and the data share one set of wires. It drives an active-high address strobe and two active-low strobes, one for reads and one for writes. It runs on a fast clock at twice the system rate, so one fast clock is half a system cycle (0.5 T). Every strobe edge therefore falls on a half-cycle boundary.

A request carries an address, a direction, a flag that marks an instruction fetch, write data, an address-wait enable (a) and a 3-bit wait-state count (n). The request is accepted only while `ready` is high. The block then puts the address on the bus and moves through the phases of a fixed sequence: address, hold, strobe and recovery. When the transfer is complete it pulses `done`. The shared bus appears as separate out, enable and in vectors, so a pad ring or a tri-state wrapper can join them.

Top module: `bus_seq`

## Requirements
- R1: During reset and right after it: `as_o`=0, `rd_n`=1, `wr_n`=1, `bus_oe`=0, `done`=0 and `ready`=1.
- R2: A request is accepted on the clock edge where `req_valid` and `ready` are both 1. On that same edge `as_o` rises and the bus starts driving `req_addr`. `as_o` then stays high for 1+2a fast clocks.
- R3: On a read, `rd_n` falls one fast clock after `as_o` falls. The address stays on the bus during that clock. `bus_oe` is 0 from the edge where `rd_n` falls.
- R4: On a write, `wr_n` falls one fast clock after `as_o` falls. The write data appears on the bus, with `bus_oe`=1, on that same edge.
- R5: The active strobe, read or write, stays low for 3+2n fast clocks, with n from 0 to 7.
- R6: After the strobe rises there is a recovery gap before `done` and `ready` return. The gap is 1 fast clock for a fetch (`req_fetch`=1, `req_write`=0), 3 fast clocks for a data read, and 1 fast clock for a write. The next `as_o` rise cannot come earlier than this.
- R7: `rdata` holds the value of `bus_in` captured at the edge where `rd_n` rises.
- R8: `ready` is 0 from acceptance until `done`. A `req_valid` or a change on the request fields in that interval has no effect on the cycle in progress.
- R9: `done` is high for exactly one fast clock. It is high in the same clock where `ready` returns to 1.
- R10: On a write, the write data stays driven through the recovery gap. `bus_oe` drops on the edge where `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the system rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch (reads only) |
| req_addr_wait | input | 1 | Adds one system cycle to the address phase |
| req_wait_n | input | WAIT_W | Number of wait states n |
| req_addr | input | BUS_W | Transfer address |
| req_wdata | input | BUS_W | Write data |
| bus_in | input | BUS_W | Value sensed on the shared bus |
| ready | output | 1 | Idle and able to accept a request |
| rdata | output | BUS_W | Captured read data |
| done | output | 1 | One-clock end-of-transfer pulse |
| as_o | output | 1 | Address strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_out | output | BUS_W | Value driven onto the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |

## Verification
Counting from the first falling edge after the accepting clock edge (index 0), the results are due at these falling edges:
- the address strobe falls at 1+2a;
- the read or write strobe falls at 2+2a;
- the strobe rises at 5+2a+2n;
- `done` arrives 1 or 3 later, depending on the cycle kind.

The bench samples only on falling clock edges. It finds each edge at the first falling edge where the level has changed and compares that index with the figure worked out from a, n and the kind of cycle. It changes `bus_in` at every falling edge, so the value expected in `rdata` is the one driven at index 4+2a+2n. Bus contents are checked at the indices where the address, the release and the write data are due.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_STRB,
    ST_RECOV
  } seq_state_e;

  // recovery gaps in fast clocks after the strobe rises
  localparam int RECOV_FETCH = 1;
  localparam int RECOV_DATA  = 3;
  localparam int RECOV_WRITE = 1;

  // base strobe low width in fast clocks (1.5 system cycles)
  localparam int STRB_BASE = 3;

endpackage

// File: rtl/bus_seq_timer.sv
module bus_seq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int WAIT_W  = 3,
  parameter int PHASE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_addr_wait,
  input  logic [WAIT_W-1:0] req_wait_n,
  output logic              ready,
  output logic              as_o,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done,
  output logic              op_write,
  output logic              ev_accept,
  output logic              ev_strb_start,
  output logic              ev_strb_end,
  output logic              ev_finish
);

  seq_state_e        state, nxt;
  logic              wr_q, fetch_q;
  logic [WAIT_W-1:0] wait_q;
  logic              t_load, t_exp;
  logic [PHASE_W-1:0] t_val;

  bus_seq_timer #(.CNT_W(PHASE_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(t_val),
    .expired (t_exp)
  );

  always_comb begin
    nxt           = state;
    t_load        = 1'b0;
    t_val         = '0;
    ev_accept     = 1'b0;
    ev_strb_start = 1'b0;
    ev_strb_end   = 1'b0;
    ev_finish     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          nxt       = ST_ADDR;
          t_load    = 1'b1;
          t_val     = req_addr_wait ? PHASE_W'(2) : '0;
          ev_accept = 1'b1;
        end
      end
      ST_ADDR: begin
        if (t_exp) begin
          nxt    = ST_HOLD;
          t_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (t_exp) begin
          nxt           = ST_STRB;
          t_load        = 1'b1;
          t_val         = PHASE_W'(STRB_BASE - 1) + (PHASE_W'(wait_q) << 1);
          ev_strb_start = 1'b1;
        end
      end
      ST_STRB: begin
        if (t_exp) begin
          nxt         = ST_RECOV;
          t_load      = 1'b1;
          if (wr_q)         t_val = PHASE_W'(RECOV_WRITE - 1);
          else if (fetch_q) t_val = PHASE_W'(RECOV_FETCH - 1);
          else              t_val = PHASE_W'(RECOV_DATA - 1);
          ev_strb_end = 1'b1;
        end
      end
      ST_RECOV: begin
        if (t_exp) begin
          nxt       = ST_IDLE;
          ev_finish = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      wait_q  <= '0;
      as_o    <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      state <= nxt;
      if (ev_accept) begin
        wr_q    <= req_write;
        fetch_q <= req_fetch & ~req_write;
        wait_q  <= req_wait_n;
      end
      as_o <= (nxt == ST_ADDR);
      rd_n <= ~((nxt == ST_STRB) && !wr_q);
      wr_n <= ~((nxt == ST_STRB) && wr_q);
      done <= ev_finish;
    end
  end

  assign ready    = (state == ST_IDLE);
  assign op_write = wr_q;

endmodule

// File: rtl/bus_seq_datapath.sv
module bus_seq_datapath #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_accept,
  input  logic             ev_strb_start,
  input  logic             ev_strb_end,
  input  logic             ev_finish,
  input  logic             op_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  output logic [BUS_W-1:0] rdata
);

  logic [BUS_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
      rdata   <= '0;
      wdata_q <= '0;
    end else begin
      if (ev_accept) begin
        bus_out <= req_addr;
        bus_oe  <= 1'b1;
        wdata_q <= req_wdata;
      end
      if (ev_strb_start) begin
        if (op_write) bus_out <= wdata_q;
        else          bus_oe  <= 1'b0;
      end
      if (ev_strb_end && !op_write) begin
        rdata <= bus_in;
      end
      if (ev_finish) begin
        bus_oe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_addr_wait,
  input  logic [WAIT_W-1:0] req_wait_n,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [BUS_W-1:0]  bus_in,
  output logic              ready,
  output logic [BUS_W-1:0]  rdata,
  output logic              done,
  output logic              as_o,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe
);

  localparam int MAX_PHASE = STRB_BASE + 2 * ((1 << WAIT_W) - 1);
  localparam int PHASE_W   = $clog2(MAX_PHASE + 1);

  logic op_write, ev_accept, ev_strb_start, ev_strb_end, ev_finish;

  bus_seq_fsm #(.WAIT_W(WAIT_W), .PHASE_W(PHASE_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_fetch    (req_fetch),
    .req_addr_wait(req_addr_wait),
    .req_wait_n   (req_wait_n),
    .ready        (ready),
    .as_o         (as_o),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .done         (done),
    .op_write     (op_write),
    .ev_accept    (ev_accept),
    .ev_strb_start(ev_strb_start),
    .ev_strb_end  (ev_strb_end),
    .ev_finish    (ev_finish)
  );

  bus_seq_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ev_accept    (ev_accept),
    .ev_strb_start(ev_strb_start),
    .ev_strb_end  (ev_strb_end),
    .ev_finish    (ev_finish),
    .op_write     (op_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .bus_in       (bus_in),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe),
    .rdata        (rdata)
  );

endmodule

// File: rtl/bus_seq_checker.sv
module bus_seq_checker (
  input logic clk,
  input logic rst,
  input logic as_o,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe,
  input logic done,
  input logic ready
);

  AST_RD_AFTER_AS_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> (!$past(as_o) && $past(as_o, 2))); // R3

  AST_WR_AFTER_AS_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> (!$past(as_o) && $past(as_o, 2))); // R4

  AST_RD_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe); // R3

  AST_WR_BUS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> bus_oe); // R4

  AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> ($past(rd_n, 3) == 1'b0)); // R5

  AST_AS_GAP_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |=> !as_o); // R6

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(as_o) |-> $past(ready)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> ready); // R9

endmodule

bind bus_seq bus_seq_checker u_bus_seq_checker (
  .clk   (clk),
  .rst   (rst),
  .as_o  (as_o),
  .rd_n  (rd_n),
  .wr_n  (wr_n),
  .bus_oe(bus_oe),
  .done  (done),
  .ready (ready)
);

// File: tb/bus_seq_bench.sv
`timescale 1ns/1ps
module bus_seq_bench;

  localparam int BUS_W  = 16;
  localparam int WAIT_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_addr_wait = 1'b0;
  logic [WAIT_W-1:0] req_wait_n = '0;
  logic [BUS_W-1:0]  req_addr = '0, req_wdata = '0, bus_in = '0;
  logic              ready, done, as_o, rd_n, wr_n, bus_oe;
  logic [BUS_W-1:0]  rdata, bus_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bus_seq #(.BUS_W(BUS_W), .WAIT_W(WAIT_W)) u_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_fetch(req_fetch), .req_addr_wait(req_addr_wait), .req_wait_n(req_wait_n),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_in(bus_in),
    .ready(ready), .rdata(rdata), .done(done), .as_o(as_o), .rd_n(rd_n),
    .wr_n(wr_n), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_recov(input int kind);
    return (kind == 1) ? 3 : 1;  // kind 0 fetch, 1 data read, 2 write
  endfunction

  function automatic logic [BUS_W-1:0] drive_val(input logic [BUS_W-1:0] base, input int i);
    return base ^ BUS_W'(i * 16'h0101);
  endfunction

  task automatic do_op(input int kind, input bit a, input int n,
                       input logic [BUS_W-1:0] addr, input logic [BUS_W-1:0] wd,
                       input logic [BUS_W-1:0] rbase, input bit poke);
    int as_fall = -1, s_fall = -1, s_rise = -1, d_at = -1;
    bit ready_bad = 0;
    bit wr = (kind == 2);
    int e_asf = 1 + 2 * int'(a);
    int e_sf  = 2 + 2 * int'(a);
    int e_sr  = 5 + 2 * int'(a) + 2 * n;
    int e_d   = e_sr + exp_recov(kind);
    @(negedge clk);
    chk(ready === 1'b1, "R8 ready before request", int'(ready), 1);
    req_valid = 1'b1; req_write = wr; req_fetch = (kind == 0);
    req_addr_wait = a; req_wait_n = WAIT_W'(n); req_addr = addr; req_wdata = wd;
    @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      logic s;
      s = wr ? wr_n : rd_n;
      req_valid = (poke && i >= 0 && i < 4) ? 1'b1 : 1'b0;
      if (poke) begin req_addr = ~addr; req_wdata = ~wd; req_write = ~wr; req_wait_n = '0; end
      if (i == 0) chk(as_o && bus_oe && bus_out == addr, "R2 address driven with strobe", int'(bus_out), int'(addr));
      if (i == e_asf) chk(bus_oe && bus_out == addr, "R3 address held after strobe fall", int'(bus_out), int'(addr));
      if (i == e_sf) begin
        if (wr) chk(bus_oe && bus_out == wd, "R4 write data with strobe", int'(bus_out), int'(wd));
        else    chk(!bus_oe, "R3 bus released at read strobe", int'(bus_oe), 0);
      end
      if (wr && i == e_d - 1) chk(bus_oe && bus_out == wd, "R10 write data held in recovery", int'(bus_out), int'(wd));
      if (wr && i == e_d) chk(!bus_oe, "R10 bus released at done", int'(bus_oe), 0);
      if (as_fall < 0 && i > 0 && !as_o) as_fall = i;
      if (s_fall < 0 && !s) s_fall = i;
      if (s_fall >= 0 && s_rise < 0 && s) s_rise = i;
      if (done) begin d_at = i; break; end
      if (ready) ready_bad = 1;
      bus_in = drive_val(rbase, i);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(as_fall == e_asf, "R2 address strobe fall index", as_fall, e_asf);
    chk(s_fall == e_sf, wr ? "R4 write strobe fall index" : "R3 read strobe fall index", s_fall, e_sf);
    chk(s_rise - s_fall == e_sr - e_sf, "R5 strobe low width", s_rise - s_fall, e_sr - e_sf);
    chk(d_at - s_rise == exp_recov(kind), "R6 recovery gap", d_at - s_rise, exp_recov(kind));
    chk(!ready_bad && ready, "R8 ready low while busy", int'(ready_bad), 0);
    if (!wr) chk(rdata == drive_val(rbase, e_sr - 1), "R7 read data capture",
                 int'(rdata), int'(drive_val(rbase, e_sr - 1)));
    @(negedge clk);
    chk(!done, "R9 done single pulse", int'(done), 0);
    chk(!as_o && rd_n && wr_n, "R8 no stray cycle after done", int'(as_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd51966));
    repeat (3) @(negedge clk);
    chk(!as_o && rd_n && wr_n && !bus_oe && !done && ready, "R1 state in reset", int'(as_o), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!as_o && rd_n && wr_n && !bus_oe && !done && ready, "R1 state after reset", int'(bus_oe), 0);
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 2; a++)
        for (int n = 0; n < 8; n++)
          do_op(k, a[0], n, BUS_W'(16'h1200 + n * 16 + a * 4 + k), BUS_W'(16'hA500 ^ n),
                BUS_W'(16'h3C00 + n), (n == 2));
    for (int r = 0; r < 30; r++)
      do_op(int'($urandom % 3), 1'($urandom), int'($urandom % 8),
            BUS_W'($urandom), BUS_W'($urandom), BUS_W'($urandom), 1'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule